// File: doc/BRIEF.md
# Vector Register Element Load/Store Sequencer

This block moves one vector register (128 bits by default) between the register file and memory, one element at a time. A single start pulse supplies the direction (load or store), a 2-bit element format, a base address and a signed 10-bit offset. The sequencer forms the start address by scaling the offset by the element size. It then issues one memory access per element, each the size of one element, in ascending element order.

The memory side is a simple request/ready port. It carries an address, a write flag, an access size and write data, and returns read data in the same cycle as ready. Only one request is ever open. A store takes its data from the register value presented at start. A load gathers every element and writes the whole register back in one cycle at the end. If an element address is not aligned to the element size, the operation stops before any request. It then reports a load or store address error together with the faulting address.

Top module: `vec_ldst_seq`

## Requirements
- R1: The start address is `base_addr + (sext(offset) << fmt)`, where `offset` is sign-extended from 10 bits and `fmt` encodes 0=byte, 1=halfword, 2=word, 3=doubleword.
- R2: A correctly aligned operation issues exactly `16 >> fmt` requests. Element i uses address start + (i << fmt), in ascending i. `mem_size` equals `fmt` and `mem_we` is 1 for a store and 0 for a load.
- R3: Only one request is open at a time. While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_size`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R4: For a store, the request for element i carries register bits [(i+1)*w-1 : i*w] in the low bits of `mem_wdata`, where w = 8 << fmt, and zeros above them. The data comes from the `vreg_rdata` value sampled at start. A store never pulses `vreg_wr_en`.
- R5: For a load, element i takes the low w bits of `mem_rdata` into register bits [(i+1)*w-1 : i*w]. Any `mem_rdata` bits above w are ignored, so narrow elements are zero-extended. The whole register appears on `vreg_wr_data` with a single `vreg_wr_en` pulse, in the same cycle as `done`.
- R6: If the element address is not a multiple of the element size, no request is issued. `done` pulses with `err_store` for a store or `err_load` for a load, and `err_addr` holds the faulting address. `vreg_wr_en` stays low.
- R7: `done` is a one-cycle pulse, one cycle after the last accepted element or the fault. `err_load` and `err_store` are never high without `done`, and never high together.
- R8: A `start` pulse while an operation is in progress is ignored. It changes neither the requests nor the result, and it does not produce an extra `done`.
- R9: After reset, `mem_req`, `done`, `vreg_wr_en`, `err_load` and `err_store` are low and `err_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_store | input | 1 | 1 = store register to memory, 0 = load |
| fmt | input | 2 | Element format: 0 byte, 1 half, 2 word, 3 double |
| base_addr | input | AW | Base address |
| offset | input | OFFW | Signed element offset |
| vreg_rdata | input | VLEN | Register value to store, sampled at start |
| vreg_wr_en | output | 1 | Register write strobe at the end of a load |
| vreg_wr_data | output | VLEN | Loaded register value |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | Access size, same encoding as fmt |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 64 | Write data, element in low bits |
| mem_ready | input | 1 | Memory accepts/completes the request this cycle |
| mem_rdata | input | 64 | Read data, valid with mem_ready |
| done | output | 1 | Operation finished (one cycle) |
| err_load | output | 1 | Load address error, with done |
| err_store | output | 1 | Store address error, with done |
| err_addr | output | AW | Faulting address of the last error |

## Verification
The bench builds the block with its defaults: VLEN=128, AW=32 and OFFW=10. This gives 16, 8, 4 and 2 elements per register and lets every format, including the full 64-bit lane, be exercised. The 10-bit offset allows negative offsets that cross address boundaries below the base. The 32-bit address gives a misaligned start both below and above a double-word boundary. The memory model returns junk above each element width, and ready stalls on every third cycle. Together these expose any missed zero-extension and any request that changes while it waits.

// File: rtl/vls_pkg.sv
package vls_pkg;

    localparam int MAX_EW = 64;

    typedef enum logic [1:0] {
        FMT_BYTE = 2'd0,
        FMT_HALF = 2'd1,
        FMT_WORD = 2'd2,
        FMT_DBL  = 2'd3
    } vfmt_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_XFER = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic  store;
        vfmt_e fmt;
    } op_t;

    function automatic logic [MAX_EW-1:0] elem_mask(vfmt_e f);
        case (f)
            FMT_BYTE: return 64'h0000_0000_0000_00FF;
            FMT_HALF: return 64'h0000_0000_0000_FFFF;
            FMT_WORD: return 64'h0000_0000_FFFF_FFFF;
            default:  return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
    import vls_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 10,
    parameter int IDXW = 4
) (
    input  logic [AW-1:0]   base_addr,
    input  logic [OFFW-1:0] offset,
    input  vfmt_e           new_fmt,
    input  logic [AW-1:0]   start_addr,
    input  logic [IDXW-1:0] idx,
    input  vfmt_e           cur_fmt,
    output logic [AW-1:0]   calc_start,
    output logic [AW-1:0]   elem_addr,
    output logic            misaligned
);
    logic [AW-1:0] off_ext;

    assign off_ext    = {{(AW-OFFW){offset[OFFW-1]}}, offset};
    assign calc_start = base_addr + (off_ext << new_fmt);
    assign elem_addr  = start_addr + (AW'(idx) << cur_fmt);

    always_comb begin
        case (cur_fmt)
            FMT_BYTE: misaligned = 1'b0;
            FMT_HALF: misaligned = elem_addr[0];
            FMT_WORD: misaligned = |elem_addr[1:0];
            default:  misaligned = |elem_addr[2:0];
        endcase
    end
endmodule

// File: rtl/vls_lane.sv
module vls_lane
    import vls_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int IDXW = 4
) (
    input  vfmt_e              fmt,
    input  logic [IDXW-1:0]    idx,
    input  logic [VLEN-1:0]    vbuf,
    input  logic [MAX_EW-1:0]  mem_rdata,
    output logic [MAX_EW-1:0]  store_elem,
    output logic [VLEN-1:0]    load_merged
);
    localparam int POSW = $clog2(VLEN);

    logic [POSW-1:0] pos;

    assign pos = POSW'({idx, 3'b000}) << fmt;

    always_comb begin
        store_elem  = '0;
        load_merged = vbuf;
        case (fmt)
            FMT_BYTE: begin
                store_elem[7:0]     = vbuf[pos +: 8];
                load_merged[pos +: 8] = mem_rdata[7:0];
            end
            FMT_HALF: begin
                store_elem[15:0]     = vbuf[pos +: 16];
                load_merged[pos +: 16] = mem_rdata[15:0];
            end
            FMT_WORD: begin
                store_elem[31:0]     = vbuf[pos +: 32];
                load_merged[pos +: 32] = mem_rdata[31:0];
            end
            default: begin
                store_elem            = vbuf[pos +: 64];
                load_merged[pos +: 64] = mem_rdata;
            end
        endcase
    end
endmodule

// File: rtl/vls_seq_ctrl.sv
module vls_seq_ctrl
    import vls_pkg::*;
#(
    parameter int NELEM_B = 16,
    parameter int IDXW    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  op_t             op_in,
    input  logic            misaligned,
    input  logic            mem_ready,
    output logic            mem_req,
    output op_t             op_q,
    output logic [IDXW-1:0] idx,
    output logic            launch,
    output logic            beat,
    output logic            fault,
    output logic            done,
    output logic            err_load,
    output logic            err_store,
    output logic            load_commit
);
    seq_state_e      state_q;
    logic [IDXW-1:0] last_idx;

    assign launch   = (state_q == SQ_IDLE) && start;
    assign mem_req  = (state_q == SQ_XFER) && !misaligned;
    assign fault    = (state_q == SQ_XFER) && misaligned;
    assign beat     = mem_req && mem_ready;
    assign last_idx = IDXW'((NELEM_B >> op_q.fmt) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SQ_IDLE;
            op_q        <= '0;
            idx         <= '0;
            done        <= 1'b0;
            err_load    <= 1'b0;
            err_store   <= 1'b0;
            load_commit <= 1'b0;
        end else begin
            done        <= 1'b0;
            err_load    <= 1'b0;
            err_store   <= 1'b0;
            load_commit <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        state_q <= SQ_XFER;
                        op_q    <= op_in;
                        idx     <= '0;
                    end
                end
                default: begin
                    if (fault) begin
                        state_q   <= SQ_IDLE;
                        done      <= 1'b1;
                        err_store <= op_q.store;
                        err_load  <= !op_q.store;
                    end else if (beat) begin
                        if (idx == last_idx) begin
                            state_q     <= SQ_IDLE;
                            done        <= 1'b1;
                            load_commit <= !op_q.store;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/vec_ldst_seq.sv
module vec_ldst_seq
    import vls_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int AW   = 32,
    parameter int OFFW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_store,
    input  logic [1:0]        fmt,
    input  logic [AW-1:0]     base_addr,
    input  logic [OFFW-1:0]   offset,
    input  logic [VLEN-1:0]   vreg_rdata,
    output logic              vreg_wr_en,
    output logic [VLEN-1:0]   vreg_wr_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [AW-1:0]     mem_addr,
    output logic [MAX_EW-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [MAX_EW-1:0] mem_rdata,
    output logic              done,
    output logic              err_load,
    output logic              err_store,
    output logic [AW-1:0]     err_addr
);
    localparam int NELEM_B = VLEN / 8;
    localparam int IDXW    = $clog2(NELEM_B);

    op_t             op_in;
    op_t             op_q;
    logic [IDXW-1:0] idx;
    logic            launch, beat, fault, misaligned;
    logic [AW-1:0]   calc_start, elem_addr;
    logic [AW-1:0]   start_addr_q;
    logic [VLEN-1:0] vbuf_q, load_merged;
    logic [MAX_EW-1:0] store_elem;

    assign op_in = '{store: op_store, fmt: vfmt_e'(fmt)};

    vls_seq_ctrl #(.NELEM_B(NELEM_B), .IDXW(IDXW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .op_in(op_in),
        .misaligned(misaligned), .mem_ready(mem_ready),
        .mem_req(mem_req), .op_q(op_q), .idx(idx), .launch(launch),
        .beat(beat), .fault(fault), .done(done), .err_load(err_load),
        .err_store(err_store), .load_commit(vreg_wr_en)
    );

    vls_addr_gen #(.AW(AW), .OFFW(OFFW), .IDXW(IDXW)) u_addr (
        .base_addr(base_addr), .offset(offset), .new_fmt(op_in.fmt),
        .start_addr(start_addr_q), .idx(idx), .cur_fmt(op_q.fmt),
        .calc_start(calc_start), .elem_addr(elem_addr),
        .misaligned(misaligned)
    );

    vls_lane #(.VLEN(VLEN), .IDXW(IDXW)) u_lane (
        .fmt(op_q.fmt), .idx(idx), .vbuf(vbuf_q), .mem_rdata(mem_rdata),
        .store_elem(store_elem), .load_merged(load_merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr_q <= '0;
            vbuf_q       <= '0;
            err_addr     <= '0;
        end else begin
            if (launch) begin
                start_addr_q <= calc_start;
                vbuf_q       <= op_store ? vreg_rdata : '0;
            end
            if (beat && !op_q.store) begin
                vbuf_q <= load_merged;
            end
            if (fault) begin
                err_addr <= elem_addr;
            end
        end
    end

    assign mem_we       = mem_req && op_q.store;
    assign mem_size     = op_q.fmt;
    assign mem_addr     = elem_addr;
    assign mem_wdata    = store_elem;
    assign vreg_wr_data = vbuf_q;
endmodule

// File: rtl/vls_ldst_checker.sv
module vls_ldst_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [1:0]    mem_size,
    input logic [AW-1:0] mem_addr,
    input logic [63:0]   mem_wdata,
    input logic          done,
    input logic          err_load,
    input logic          err_store,
    input logic          vreg_wr_en
);
    logic addr_ok;

    always_comb begin
        case (mem_size)
            2'd0:    addr_ok = 1'b1;
            2'd1:    addr_ok = (mem_addr[0] == 1'b0);
            2'd2:    addr_ok = (mem_addr[1:0] == 2'b00);
            default: addr_ok = (mem_addr[2:0] == 3'b000);
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_size)
            && $stable(mem_we) && $stable(mem_wdata)); // R3
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> addr_ok); // R6
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        (err_load || err_store) |-> done && !(err_load && err_store)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req); // R2
    AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        vreg_wr_en |-> done && !err_load && !err_store); // R5
endmodule

bind vec_ldst_seq vls_ldst_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .done(done), .err_load(err_load),
    .err_store(err_store), .vreg_wr_en(vreg_wr_en)
);

// File: tb/vec_ldst_seq_tb.sv
`timescale 1ns/1ps
module vec_ldst_seq_tb;
    localparam int VLEN = 128;
    localparam int AW   = 32;
    localparam int OFFW = 10;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst = 1'b1;
    logic            start = 1'b0, op_store = 1'b0;
    logic [1:0]      fmt = 2'd0;
    logic [AW-1:0]   base_addr = '0;
    logic [OFFW-1:0] offset = '0;
    logic [VLEN-1:0] vreg_rdata = '0;
    logic            vreg_wr_en;
    logic [VLEN-1:0] vreg_wr_data;
    logic            mem_req, mem_we, mem_ready = 1'b1;
    logic [1:0]      mem_size;
    logic [AW-1:0]   mem_addr, err_addr;
    logic [63:0]     mem_wdata, mem_rdata;
    logic            done, err_load, err_store;

    vec_ldst_seq #(.VLEN(VLEN), .AW(AW), .OFFW(OFFW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op_store(op_store), .fmt(fmt),
        .base_addr(base_addr), .offset(offset), .vreg_rdata(vreg_rdata),
        .vreg_wr_en(vreg_wr_en), .vreg_wr_data(vreg_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .done(done), .err_load(err_load),
        .err_store(err_store), .err_addr(err_addr)
    );

    function automatic logic [63:0] mdata(logic [31:0] a);
        return {(a * 32'd3) ^ 32'h5a5a_1234, a ^ 32'hc3c3_0f0f};
    endfunction
    assign mem_rdata = mdata(mem_addr);

    typedef struct packed {
        logic        we;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [63:0] wdata;
    } txn_t;

    txn_t exp_q[$];
    int   n_checks = 0, n_fail = 0;
    bit   finished = 0;

    task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ready pattern: stall every third cycle when enabled
    bit stall_en = 0;
    int cyc = 0;
    initial forever begin
        @(negedge clk);
        cyc++;
        mem_ready = !(stall_en && (cyc % 3 == 0));
    end

    // monitor: pops expected requests, records completions
    int done_cnt = 0;
    logic seen_wr, seen_el, seen_es;
    logic [127:0] seen_data;
    logic [31:0]  seen_eaddr;
    bit   prev_wait = 0;
    txn_t prev_t;
    initial forever begin
        txn_t cur, t;
        @(negedge clk);
        #1;
        if (!rst) begin
            cur = '{we: mem_we, size: mem_size, addr: mem_addr, wdata: mem_wdata};
            if (prev_wait)
                check(mem_req && cur == prev_t, "R3", "request held while waiting", cur, prev_t);
            if (mem_req && mem_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected request", cur, '0);
                end else begin
                    t = exp_q.pop_front();
                    check(cur.we == t.we && cur.size == t.size && cur.addr == t.addr,
                          "R2", "request addr/size/we", cur, t);
                    if (t.we)
                        check(cur.wdata == t.wdata, "R4", "store data", cur.wdata, t.wdata);
                end
            end
            if (done) begin
                done_cnt++;
                seen_wr    = vreg_wr_en;
                seen_data  = vreg_wr_data;
                seen_el    = err_load;
                seen_es    = err_store;
                seen_eaddr = err_addr;
            end
            prev_wait = mem_req && !mem_ready;
            prev_t    = cur;
        end
    end

    task automatic run_op(bit st, logic [1:0] f, logic [31:0] b, logic [9:0] o,
                          logic [127:0] v, bit dup);
        logic [31:0]  sa;
        logic [63:0]  mask;
        logic [127:0] exp_vec;
        bit           mis;
        int           n, w, d0;
        txn_t         t;
        sa   = b + ({{22{o[9]}}, o} << f);
        n    = 16 >> f;
        w    = 8 << f;
        mis  = (sa & ((32'd1 << f) - 32'd1)) != 0;
        mask = (f == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        exp_vec = '0;
        if (!mis) begin
            for (int i = 0; i < n; i++) begin
                t.we    = st;
                t.size  = f;
                t.addr  = sa + (32'(i) << f);
                t.wdata = 64'((v >> (i * w))) & mask;
                exp_q.push_back(t);
                exp_vec |= 128'(mdata(t.addr) & mask) << (i * w);
            end
        end
        @(negedge clk);
        d0 = done_cnt;
        start = 1'b1; op_store = st; fmt = f; base_addr = b; offset = o; vreg_rdata = v;
        @(negedge clk);
        start = 1'b0;
        if (dup) begin
            repeat (2) @(negedge clk);
            start = 1'b1; op_store = ~st; fmt = 2'd0; base_addr = 32'h0000_0001;
            offset = 10'h155; vreg_rdata = ~v;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "requests left unissued", 128'(exp_q.size()), '0);
        check(done_cnt == d0 + 1, "R8", "done count per operation", 128'(done_cnt - d0), 128'd1);
        if (mis) begin
            check(seen_es == st && seen_el == !st, "R6", "error kind {el,es}",
                  {seen_el, seen_es}, {!st, st});
            check(seen_eaddr == sa, "R6", "fault address", seen_eaddr, sa);
            check(!seen_wr, "R6", "no register write on fault", seen_wr, 1'b0);
            exp_q.delete();
        end else begin
            check(!seen_el && !seen_es, "R7", "no error on aligned op", {seen_el, seen_es}, 2'b00);
            if (st)
                check(!seen_wr, "R4", "store does not write register", seen_wr, 1'b0);
            else
                check(seen_wr && seen_data == exp_vec, "R5", "loaded register", seen_data, exp_vec);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        check(!mem_req && !done && !vreg_wr_en && !err_load && !err_store,
              "R9", "control outputs after reset",
              {mem_req, done, vreg_wr_en, err_load, err_store}, '0);
        check(err_addr == '0, "R9", "err_addr after reset", err_addr, '0);

        // R1 R2 R5 loads, each format, positive and negative offsets
        run_op(0, 2'd0, 32'h0000_1000, 10'd3,   '0, 0);
        run_op(0, 2'd1, 32'h0000_2000, 10'h3FE, '0, 0);
        run_op(0, 2'd2, 32'h0000_3004, 10'd5,   '0, 0);
        run_op(0, 2'd3, 32'h0000_4000, 10'h3FF, '0, 0);
        run_op(0, 2'd3, 32'h0000_8000, 10'h200, '0, 0); // R1 most negative offset

        // R4 stores with stalls (R3)
        stall_en = 1;
        run_op(1, 2'd0, 32'h0000_9000, 10'd7, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1); // R8
        run_op(1, 2'd1, 32'h0000_A002, 10'd1, 128'hDEAD_BEEF_CAFE_F00D_1122_3344_5566_7788, 0);
        run_op(1, 2'd2, 32'h0000_B000, 10'h3FC, 128'hA5A5_5A5A_0F0F_F0F0_1357_9BDF_2468_ACE0, 0);
        run_op(1, 2'd3, 32'h0000_C008, 10'd2, 128'h8000_0000_0000_0001_7FFF_FFFF_FFFF_FFFE, 0);
        run_op(0, 2'd0, 32'h0000_D0F0, 10'h3F0, '0, 1); // R8 during load, R5 with stalls
        run_op(0, 2'd2, 32'h0000_E010, 10'd1, '0, 0);

        // R6 misaligned
        stall_en = 0;
        run_op(0, 2'd2, 32'h0000_5002, 10'd0, '0, 0);
        run_op(1, 2'd3, 32'h0000_6004, 10'd1, 128'h1, 0);
        run_op(0, 2'd1, 32'h0000_7001, 10'd0, '0, 0);
        run_op(1, 2'd3, 32'h0000_6FFC, 10'd0, 128'h2, 0);

        finish_run();
    end
endmodule